// File: doc/BRIEF.md
# Two-Channel Quadrature Integrating Monitor

This block watches one ADC sample stream and turns it into a pair of running quadrature sums. Each sample is multiplied by a cosine and by a sine local-oscillator word. Each product is cut down to a few guard bits above the ADC width. It then feeds two cascaded wrapping accumulators, which form the integrator half of a second-order CIC decimator. The comb half, the decimation timing and the oscillator itself sit outside the block.

A capture strobe copies both second-stage sums into a two-word output chain. The chain is read out over a daisy-chained word bus. While the shift gate is high, each clock moves the chain forward one word and takes the upstream word in at its tail. The gate is passed on one clock late, so many monitors can share one readout path, each feeding the next. The bus has no back-pressure. The reader raises the gate for exactly as many clocks as it wants words, and a word leaves only on a gated clock. Every multiplier and adder is followed by a register, so the block meets an 8.4 ns clock.

Top module: `iqmon_top`

## Requirements
- R1: Both channels use the same ADC sample, taken as signed two's complement. Channel 0 multiplies it by the signed cosine word and channel 1 by the signed sine word.
- R2: Each full product keeps only its top ADC_W+GUARD bits. With the defaults (16 x 18 gives a 34-bit product) these are bits 33..15, the same as an arithmetic right shift by 15. The kept value is sign-extended to RES_W bits.
- R3: Each channel has two accumulators, and both wrap modulo 2^RES_W. The first adds the truncated product on every clock. The second adds the first accumulator's registered value. Inputs sampled on edge k reach the first accumulator on edge k+2 and the second on edge k+3.
- R4: When the capture strobe is high at an edge, the chain head (chain word 0) takes the channel 0 second-stage sum held before that edge. The tail (chain word 1) takes the channel 1 sum. Capture overrides the gate.
- R5: When the gate is high and the capture strobe is low at an edge, the tail moves to the head and the stream-in word enters the tail. The stream output always shows the head.
- R6: When both the gate and the capture strobe are low, the stream output holds its value, whatever arrives on stream-in.
- R7: The gate output equals the gate input delayed by one clock.
- R8: A synchronous reset sets the stream output, the gate output, the multiplier pipeline and all accumulators to zero. After release, a capture on the second edge returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous active-high reset |
| adc_in | input | ADC_W | Signed ADC sample |
| lo_cos | input | LO_W | Signed cosine oscillator word |
| lo_sin | input | LO_W | Signed sine oscillator word |
| cap_strobe | input | 1 | Latch both second-stage sums into the chain |
| chain_in | input | RES_W | Word from the upstream monitor |
| chain_out | output | RES_W | Head word of the output chain |
| gate_in | input | 1 | Shift enable for the chain |
| gate_out | output | 1 | Shift enable passed downstream, one clock late |

## Verification
A fault in the mixer or in the truncation shows at the ports only after a capture. It appears as a wrong head word on the clock after the strobe, and the sine-channel word follows one gated clock later. Because the accumulators integrate, a single wrong product or carry does not fade. It shifts every later capture by a growing amount, so any capture after the fault exposes it. A wrong chain or gate state shows within one clock as a moved, missing or stale word on the stream, or as a misaligned gate output.

// File: rtl/iqmon_pkg.sv
package iqmon_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic [0:0] {CH_COS = 1'b0, CH_SIN = 1'b1} ch_e;
endpackage

// File: rtl/iqmon_mixer.sv
module iqmon_mixer #(
  parameter int ADC_W = 16,
  parameter int LO_W  = 18,
  parameter int RES_W = 28,
  parameter int GUARD = 3
) (
  input  logic                    clk,
  input  logic                    reset,
  input  logic signed [ADC_W-1:0] adc,
  input  logic signed [LO_W-1:0]  lo,
  output logic [RES_W-1:0]        prod_ext
);
  localparam int PROD_W = ADC_W + LO_W;
  localparam int KEEP_W = ADC_W + GUARD;
  localparam int DROP_W = PROD_W - KEEP_W;

  logic signed [ADC_W-1:0]  adc_q;
  logic signed [LO_W-1:0]   lo_q;
  logic signed [PROD_W-1:0] prod_q;
  logic signed [KEEP_W-1:0] kept;

  // operand register, then product register
  always_ff @(posedge clk) begin
    if (reset) begin
      adc_q  <= '0;
      lo_q   <= '0;
      prod_q <= '0;
    end else begin
      adc_q  <= adc;
      lo_q   <= lo;
      prod_q <= PROD_W'(adc_q) * PROD_W'(lo_q);
    end
  end

  assign kept     = prod_q[PROD_W-1:DROP_W];
  assign prod_ext = RES_W'(kept);
endmodule

// File: rtl/iqmon_integ2.sv
module iqmon_integ2 #(
  parameter int RES_W = 28
) (
  input  logic             clk,
  input  logic             reset,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] acc1,
  output logic [RES_W-1:0] acc2
);
  always_ff @(posedge clk) begin
    if (reset) begin
      acc1 <= '0;
      acc2 <= '0;
    end else begin
      acc1 <= acc1 + din;
      acc2 <= acc2 + acc1;
    end
  end
endmodule

// File: rtl/iqmon_shift.sv
module iqmon_shift #(
  parameter int RES_W = 28,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             load,
  input  logic [RES_W-1:0] load_word [DEPTH],
  input  logic             shift,
  input  logic [RES_W-1:0] s_in,
  output logic [RES_W-1:0] head
);
  logic [RES_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (reset) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= load_word[i];
    end else if (shift) begin
      for (int i = 0; i < DEPTH - 1; i++) word_q[i] <= word_q[i+1];
      word_q[DEPTH-1] <= s_in;
    end
  end

  assign head = word_q[0];
endmodule

// File: rtl/iqmon_top.sv
module iqmon_top
  import iqmon_pkg::*;
#(
  parameter int ADC_W = 16,
  parameter int LO_W  = 18,
  parameter int RES_W = 28,
  parameter int GUARD = 3
) (
  input  logic                    clk,
  input  logic                    reset,
  input  logic signed [ADC_W-1:0] adc_in,
  input  logic signed [LO_W-1:0]  lo_cos,
  input  logic signed [LO_W-1:0]  lo_sin,
  input  logic                    cap_strobe,
  input  logic [RES_W-1:0]        chain_in,
  output logic [RES_W-1:0]        chain_out,
  input  logic                    gate_in,
  output logic                    gate_out
);
  logic signed [LO_W-1:0] lo_w   [NUM_CH];
  logic [RES_W-1:0]       prod_w [NUM_CH];
  logic [RES_W-1:0]       acc1_w [NUM_CH];
  logic [RES_W-1:0]       acc2_w [NUM_CH];

  assign lo_w[CH_COS] = lo_cos;
  assign lo_w[CH_SIN] = lo_sin;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    iqmon_mixer #(
      .ADC_W(ADC_W), .LO_W(LO_W), .RES_W(RES_W), .GUARD(GUARD)
    ) mix_i (
      .clk(clk), .reset(reset), .adc(adc_in), .lo(lo_w[c]),
      .prod_ext(prod_w[c])
    );

    iqmon_integ2 #(.RES_W(RES_W)) integ_i (
      .clk(clk), .reset(reset), .din(prod_w[c]),
      .acc1(acc1_w[c]), .acc2(acc2_w[c])
    );
  end

  iqmon_shift #(.RES_W(RES_W), .DEPTH(NUM_CH)) shift_i (
    .clk(clk), .reset(reset), .load(cap_strobe), .load_word(acc2_w),
    .shift(gate_in), .s_in(chain_in), .head(chain_out)
  );

  always_ff @(posedge clk) begin
    if (reset) gate_out <= 1'b0;
    else       gate_out <= gate_in;
  end
endmodule

// File: rtl/iqmon_chk.sv
module iqmon_chk #(
  parameter int RES_W = 28
) (
  input logic             clk,
  input logic             reset,
  input logic             cap_strobe,
  input logic             gate_in,
  input logic             gate_out,
  input logic [RES_W-1:0] chain_in,
  input logic [RES_W-1:0] chain_out,
  input logic [RES_W-1:0] acc1_cos,
  input logic [RES_W-1:0] acc2_cos,
  input logic [RES_W-1:0] prod_cos
);
  assert_reset_clear_R8: assert property (@(posedge clk)
    reset |=> (chain_out == '0 && gate_out == 1'b0));

  assert_gate_delay_R7: assert property (@(posedge clk) disable iff (reset)
    !reset |=> gate_out == $past(gate_in));

  assert_hold_R6: assert property (@(posedge clk) disable iff (reset)
    (!cap_strobe && !gate_in) |=> $stable(chain_out));

  assert_capture_R4: assert property (@(posedge clk) disable iff (reset)
    cap_strobe |=> chain_out == $past(acc2_cos));

  assert_shift_R5: assert property (@(posedge clk) disable iff (reset)
    (!cap_strobe && gate_in) ##1 (!cap_strobe && gate_in) |=> chain_out == $past(chain_in, 2));

  assert_integ_R3: assert property (@(posedge clk) disable iff (reset)
    !reset |=> acc1_cos == $past(acc1_cos + prod_cos));
endmodule

bind iqmon_top iqmon_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .reset(reset), .cap_strobe(cap_strobe), .gate_in(gate_in),
  .gate_out(gate_out), .chain_in(chain_in), .chain_out(chain_out),
  .acc1_cos(acc1_w[0]), .acc2_cos(acc2_w[0]), .prod_cos(prod_w[0])
);

// File: tb/iqmon_top_tb_top.sv
`timescale 1ns/1ps
module iqmon_top_tb_top;
  logic               clk = 1'b0;
  logic               reset = 1'b1;
  logic signed [15:0] adc_in = '0;
  logic signed [17:0] lo_cos = '0;
  logic signed [17:0] lo_sin = '0;
  logic               cap_strobe = 1'b0;
  logic [27:0]        chain_in = '0;
  logic [27:0]        chain_out;
  logic               gate_in = 1'b0;
  logic               gate_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  iqmon_top dut_i (
    .clk(clk), .reset(reset), .adc_in(adc_in), .lo_cos(lo_cos), .lo_sin(lo_sin),
    .cap_strobe(cap_strobe), .chain_in(chain_in), .chain_out(chain_out),
    .gate_in(gate_in), .gate_out(gate_out)
  );

  // reference built from R1..R8
  function automatic logic [27:0] trunc_ext(input logic signed [15:0] a,
                                            input logic signed [17:0] b);
    logic signed [33:0] p;
    p = 34'(a) * 34'(b);
    return 28'(p >>> 15);
  endfunction

  logic signed [15:0] m_a;
  logic signed [17:0] m_c, m_s;
  logic [27:0] m_pc, m_ps, m_i1c, m_i1s, m_i2c, m_i2s, m_head, m_tail;
  logic        m_g;

  always @(posedge clk) begin
    if (reset) begin
      m_a <= '0; m_c <= '0; m_s <= '0; m_pc <= '0; m_ps <= '0;
      m_i1c <= '0; m_i1s <= '0; m_i2c <= '0; m_i2s <= '0;
      m_head <= '0; m_tail <= '0; m_g <= 1'b0;
    end else begin
      m_a <= adc_in; m_c <= lo_cos; m_s <= lo_sin;
      m_pc <= trunc_ext(m_a, m_c);
      m_ps <= trunc_ext(m_a, m_s);
      m_i1c <= m_i1c + m_pc; m_i1s <= m_i1s + m_ps;
      m_i2c <= m_i2c + m_i1c; m_i2s <= m_i2s + m_i1s;
      if (cap_strobe) begin
        m_head <= m_i2c; m_tail <= m_i2s;
      end else if (gate_in) begin
        m_head <= m_tail; m_tail <= chain_in;
      end
      m_g <= gate_in;
    end
  end

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic capture(output logic [27:0] cos_w, output logic [27:0] sin_w);
    cos_w = m_i2c; sin_w = m_i2s;   // sums held before the capture edge
    cap_strobe = 1'b1; step();
    cap_strobe = 1'b0;
  endtask

  task automatic t_reset();
    reset = 1'b1; adc_in = 16'sd999; lo_cos = 18'sd777; gate_in = 1'b1;
    step(3);
    chk("R8 reset stream", chain_out, 28'd0);
    chk("R8 reset gate", {27'd0, gate_out}, 28'd0);
    reset = 1'b0; gate_in = 1'b0;
  endtask

  task automatic t_capture_shift();
    logic [27:0] cw, sw;
    adc_in = 16'sd1234; lo_cos = 18'sd50000; lo_sin = -18'sd40000;
    step(20);
    capture(cw, sw);
    chk("R1 R4 capture cos head", chain_out, cw);
    chk("R2 R3 model cos", chain_out, m_head);
    gate_in = 1'b1; chain_in = 28'hABC_DEF0; step();
    chk("R5 shift sin word", chain_out, sw);
    chain_in = 28'h123_4567; step();
    chk("R5 shift upstream 1", chain_out, 28'hABC_DEF0);
    step();
    chk("R5 shift upstream 2", chain_out, 28'h123_4567);
    gate_in = 1'b0;
  endtask

  task automatic t_negative();
    logic [27:0] cw, sw;
    adc_in = -16'sd30000; lo_cos = -18'sd100000; lo_sin = 18'sd70000;
    step(7);
    capture(cw, sw);
    chk("R1 R2 negative cos", chain_out, cw);
    gate_in = 1'b1; step(); gate_in = 1'b0;
    chk("R1 R2 negative sin", chain_out, sw);
    chk("R2 model sin", chain_out, m_head);
  endtask

  task automatic t_hold();
    logic [27:0] cw, sw;
    step(3);
    capture(cw, sw);
    for (int i = 0; i < 5; i++) begin
      chain_in = 28'(i * 28'h111_1111 + 5);
      step();
      chk("R6 hold with gate low", chain_out, cw);
    end
    gate_in = 1'b1; step(); gate_in = 1'b0;
    chk("R6 tail kept while held", chain_out, sw);
  endtask

  task automatic t_gate();
    logic prev;
    logic [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      gate_in = pat[i]; prev = pat[i];
      step();
      chk("R7 gate delay", {27'd0, gate_out}, {27'd0, prev});
    end
    gate_in = 1'b0;
  endtask

  task automatic t_priority();
    logic [27:0] cw, sw;
    step(2);
    gate_in = 1'b1; chain_in = 28'hFFF_0000;
    capture(cw, sw);
    chk("R4 capture beats gate", chain_out, cw);
    gate_in = 1'b0; step();
    chk("R4 head stays after", chain_out, cw);
  endtask

  task automatic t_wrap();
    logic [27:0] cw, sw;
    adc_in = 16'sd32767; lo_cos = 18'sd131071; lo_sin = -18'sd131072;
    step(150);
    capture(cw, sw);
    chk("R3 wrap cos", chain_out, cw);
    gate_in = 1'b1; step(); gate_in = 1'b0;
    chk("R3 wrap sin", chain_out, sw);
  endtask

  task automatic t_reset_mid();
    reset = 1'b1; step();
    chk("R8 mid reset stream", chain_out, 28'd0);
    reset = 1'b0; step();
    cap_strobe = 1'b1; step(); cap_strobe = 1'b0;
    chk("R8 capture after release", chain_out, 28'd0);
    step(10);
    chk("R8 model tracks", chain_out, m_head);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_capture_shift();
    t_negative();
    t_hold();
    t_gate();
    t_priority();
    t_wrap();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule